// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This unit sits beside the execute stage of a RISC core and handles the two instructions that move values between general registers and the special-purpose register space. Each request gives a direction, a 12-bit register address and, for a move-to, a data word. The unit checks the privilege bits from the status register and validates the address. A move-from is checked against a read whitelist and a move-to against a separate write whitelist. The unit then issues the result one cycle later.

A move-from returns the value of the selected register. The register contents belong to other units and are brought in on plain input buses. The shadow register window is read through an index output, and the storage behind it answers combinationally. A move-to produces a one-hot write enable with the data, for the unit that owns the target register. Some targets carry side effects. A status-register write forces the fixed-one bit to 1. A next-PC write becomes a fetch redirect and clears the pending delay-slot state. The tick-timer mode register accepts only a zero write, which has no effect. A single error output pulses for any access that fails.

Top module: `spr_access_unit`

## Requirements
- R1: A request (opValid high) is permitted only when supMode or userAccess is high. Otherwise the response one cycle later has rspErr=1, rdData=0, all wrEn bits 0 and redirect=0.
- R2: Any address at or above IMPL_COUNT (default 0x800) is invalid. The response has rspErr=1, rdData=0, and no write or redirect.
- R3: A permitted read of a readable address returns that register's value on rdData with rspErr=0. The readable addresses are 0x000 version, 0x001 unit-present, 0x002 config, 0x011 status, 0x012 previous-PC, 0x014 FP control, 0x020 exception-PC, 0x280 MAC low and 0x281 MAC high. Any other in-range read outside the window gives rdData=0 and rspErr=1.
- R4: A permitted write to 0x014, 0x020, 0x040 (exception status), 0x280 or 0x281 sets exactly one wrEn bit, with wrDataOut equal to opData. The bit index is 0 for FP control, 1 for exception-PC, 2 for exception status, 3 for MAC low and 4 for MAC high. Any other in-range write address outside the window that is not named in R5 to R7 gives rspErr=1 and no write.
- R5: A permitted write to the status register 0x011 sets wrEn bit 5, with wrDataOut equal to opData with bit FO_BIT (default 15) forced to 1.
- R6: A permitted write to next-PC 0x010 produces no write enable. Instead it raises redirect and dsClear, with redirectPc equal to opData.
- R7: A permitted write to the timer mode address 0x600 produces no write enable and no redirect. rspErr is 0 when opData is zero and 1 otherwise.
- R8: Every response appears exactly one cycle after the request, with rspValid=1. While rspValid=0, every output other than shadowRdIdx is 0. Within a response, every data field that is not in use is 0.
- R9: While rst_n is low, every registered output is 0, whatever the inputs are.
- R10: The shadow window covers addresses 0x400 to 0x5FF. shadowRdIdx equals the address minus 0x400. A permitted read returns shadowRdData. A permitted write sets wrEn bit 6, with wrDataOut equal to opData and wrIdx equal to the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request present this cycle |
| opWrite | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| opAddr | input | ADDR_W | Special-register address |
| opData | input | DATA_W | Write data |
| supMode | input | 1 | Supervisor-mode status bit |
| userAccess | input | 1 | User special-register access status bit |
| verVal | input | DATA_W | Version register value |
| unitVal | input | DATA_W | Unit-present register value |
| cfgVal | input | DATA_W | Configuration register value |
| statVal | input | DATA_W | Status register value |
| prevPcVal | input | DATA_W | Previous-PC register value |
| fpCtlVal | input | DATA_W | FP control/status register value |
| excPcVal | input | DATA_W | Exception-PC register value |
| macLoVal | input | DATA_W | MAC accumulator low value |
| macHiVal | input | DATA_W | MAC accumulator high value |
| shadowRdIdx | output | IDX_W | Shadow window read index (combinational) |
| shadowRdData | input | DATA_W | Shadow window read data for shadowRdIdx |
| rspValid | output | 1 | Response valid |
| rspErr | output | 1 | Access error pulse |
| rdData | output | DATA_W | Read result |
| wrEn | output | 7 | One-hot write enable per target |
| wrDataOut | output | DATA_W | Write data to the target |
| wrIdx | output | IDX_W | Shadow window write index |
| redirect | output | 1 | Fetch redirect pulse |
| redirectPc | output | DATA_W | Redirect target |
| dsClear | output | 1 | Clear pending delay-slot state |

## Verification
Some properties are checked on every cycle, independent of the address map. Privilege denial and out-of-range addresses must always give an error with no write or redirect. A zero timer-mode write must never give an error. The write enables must stay one-hot or zero, every status write must carry the fixed-one bit, and a redirect must never coincide with a write. The idle cycles must stay quiet. Only the bench's sweeps can show the full map. Those sweeps cover every address in both directions under each privilege combination. They show that each whitelist entry selects the right source or target, that the read and write lists differ exactly where intended, that window offsets line up, and that the data values and the one-cycle latency are correct.

// File: rtl/spr_access_pkg.sv
package spr_access_pkg;

  // Fixed special-register addresses
  localparam int ADR_VER     = 'h000;
  localparam int ADR_UNIT    = 'h001;
  localparam int ADR_CFG     = 'h002;
  localparam int ADR_NEXTPC  = 'h010;
  localparam int ADR_STAT    = 'h011;
  localparam int ADR_PREVPC  = 'h012;
  localparam int ADR_FPCTL   = 'h014;
  localparam int ADR_EXCPC   = 'h020;
  localparam int ADR_EXCSTAT = 'h040;
  localparam int ADR_MACLO   = 'h280;
  localparam int ADR_MACHI   = 'h281;
  localparam int ADR_TMRMODE = 'h600;

  // Write target indices (bit positions of wrEn)
  localparam int WT_FPCTL   = 0;
  localparam int WT_EXCPC   = 1;
  localparam int WT_EXCSTAT = 2;
  localparam int WT_MACLO   = 3;
  localparam int WT_MACHI   = 4;
  localparam int WT_STAT    = 5;
  localparam int WT_SHADOW  = 6;
  localparam int WT_COUNT   = 7;

  typedef enum logic [3:0] {
    RD_NONE, RD_VER, RD_UNIT, RD_CFG, RD_STAT, RD_PREVPC,
    RD_FPCTL, RD_EXCPC, RD_MACLO, RD_MACHI, RD_SHADOW
  } rdSel_e;

  typedef struct packed {
    logic                respond;
    rdSel_e              rdSel;
    logic [WT_COUNT-1:0] wrStrobe;
    logic                redirect;
    logic                fault;
  } ctlStrobes_t;

endpackage

// File: rtl/spr_access_ctrl.sv
module spr_access_ctrl
  import spr_access_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int IMPL_COUNT   = 'h800,
  parameter int SHADOW_BASE  = 'h400,
  parameter int SHADOW_DEPTH = 512
) (
  input  logic              opValid,
  input  logic              opWrite,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic              supMode,
  input  logic              userAccess,
  output ctlStrobes_t       strobes
);

  localparam int WIN_END = SHADOW_BASE + SHADOW_DEPTH;

  logic [31:0]         addrWide;
  logic                privOk;
  logic                inRange;
  logic                inWindow;
  rdSel_e              rdHit;
  logic [WT_COUNT-1:0] wrHit;
  logic                npcHit;
  logic                tmrHit;

  assign addrWide = 32'(opAddr);
  assign privOk   = supMode | userAccess;
  assign inRange  = addrWide < 32'(IMPL_COUNT);
  assign inWindow = (addrWide >= 32'(SHADOW_BASE)) && (addrWide < 32'(WIN_END));

  // Read whitelist
  always_comb begin
    rdHit = RD_NONE;
    if (inWindow) begin
      rdHit = RD_SHADOW;
    end else begin
      case (addrWide)
        ADR_VER:    rdHit = RD_VER;
        ADR_UNIT:   rdHit = RD_UNIT;
        ADR_CFG:    rdHit = RD_CFG;
        ADR_STAT:   rdHit = RD_STAT;
        ADR_PREVPC: rdHit = RD_PREVPC;
        ADR_FPCTL:  rdHit = RD_FPCTL;
        ADR_EXCPC:  rdHit = RD_EXCPC;
        ADR_MACLO:  rdHit = RD_MACLO;
        ADR_MACHI:  rdHit = RD_MACHI;
        default:    rdHit = RD_NONE;
      endcase
    end
  end

  // Write whitelist and side-effect targets
  always_comb begin
    wrHit  = '0;
    npcHit = 1'b0;
    tmrHit = 1'b0;
    if (inWindow) begin
      wrHit[WT_SHADOW] = 1'b1;
    end else begin
      case (addrWide)
        ADR_FPCTL:   wrHit[WT_FPCTL]   = 1'b1;
        ADR_EXCPC:   wrHit[WT_EXCPC]   = 1'b1;
        ADR_EXCSTAT: wrHit[WT_EXCSTAT] = 1'b1;
        ADR_MACLO:   wrHit[WT_MACLO]   = 1'b1;
        ADR_MACHI:   wrHit[WT_MACHI]   = 1'b1;
        ADR_STAT:    wrHit[WT_STAT]    = 1'b1;
        ADR_NEXTPC:  npcHit            = 1'b1;
        ADR_TMRMODE: tmrHit            = 1'b1;
        default:     ;
      endcase
    end
  end

  // Strobe generation: privilege, then range, then whitelist
  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    if (opValid) begin
      strobes.respond = 1'b1;
      if (!privOk || !inRange) begin
        strobes.fault = 1'b1;
      end else if (!opWrite) begin
        if (rdHit == RD_NONE) strobes.fault = 1'b1;
        else                  strobes.rdSel = rdHit;
      end else begin
        if (wrHit != '0)  strobes.wrStrobe = wrHit;
        else if (npcHit)  strobes.redirect = 1'b1;
        else if (tmrHit)  strobes.fault    = (opData != '0);
        else              strobes.fault    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spr_access_datapath.sv
module spr_access_datapath
  import spr_access_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SHADOW_BASE = 'h400,
  parameter int IDX_W       = 9,
  parameter int FO_BIT      = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [DATA_W-1:0]   opData,
  input  logic [DATA_W-1:0]   verVal,
  input  logic [DATA_W-1:0]   unitVal,
  input  logic [DATA_W-1:0]   cfgVal,
  input  logic [DATA_W-1:0]   statVal,
  input  logic [DATA_W-1:0]   prevPcVal,
  input  logic [DATA_W-1:0]   fpCtlVal,
  input  logic [DATA_W-1:0]   excPcVal,
  input  logic [DATA_W-1:0]   macLoVal,
  input  logic [DATA_W-1:0]   macHiVal,
  output logic [IDX_W-1:0]    shadowRdIdx,
  input  logic [DATA_W-1:0]   shadowRdData,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rdData,
  output logic [WT_COUNT-1:0] wrEn,
  output logic [DATA_W-1:0]   wrDataOut,
  output logic [IDX_W-1:0]    wrIdx,
  output logic                redirect,
  output logic [DATA_W-1:0]   redirectPc,
  output logic                dsClear
);

  localparam logic [DATA_W-1:0] FO_MASK = DATA_W'(1) << FO_BIT;

  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] wrDataNext;
  logic [IDX_W-1:0]  idxNext;
  logic              anyWrite;

  assign shadowRdIdx = IDX_W'(32'(opAddr) - 32'(SHADOW_BASE));
  assign anyWrite    = (strobes.wrStrobe != '0);

  always_comb begin
    case (strobes.rdSel)
      RD_VER:    rdNext = verVal;
      RD_UNIT:   rdNext = unitVal;
      RD_CFG:    rdNext = cfgVal;
      RD_STAT:   rdNext = statVal;
      RD_PREVPC: rdNext = prevPcVal;
      RD_FPCTL:  rdNext = fpCtlVal;
      RD_EXCPC:  rdNext = excPcVal;
      RD_MACLO:  rdNext = macLoVal;
      RD_MACHI:  rdNext = macHiVal;
      RD_SHADOW: rdNext = shadowRdData;
      default:   rdNext = '0;
    endcase
  end

  always_comb begin
    wrDataNext = '0;
    if (anyWrite) begin
      wrDataNext = opData;
      if (strobes.wrStrobe[WT_STAT]) wrDataNext = opData | FO_MASK;
    end
  end

  assign idxNext = strobes.wrStrobe[WT_SHADOW] ? shadowRdIdx : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspErr     <= 1'b0;
      rdData     <= '0;
      wrDataOut  <= '0;
      wrIdx      <= '0;
      redirect   <= 1'b0;
      redirectPc <= '0;
      dsClear    <= 1'b0;
    end else begin
      rspValid   <= strobes.respond;
      rspErr     <= strobes.fault;
      rdData     <= rdNext;
      wrDataOut  <= wrDataNext;
      wrIdx      <= idxNext;
      redirect   <= strobes.redirect;
      redirectPc <= strobes.redirect ? opData : '0;
      dsClear    <= strobes.redirect;
    end
  end

  // One enable flop per write target
  for (genvar t = 0; t < WT_COUNT; t++) begin : g_wrEn
    always_ff @(posedge clk) begin
      if (!rst_n) wrEn[t] <= 1'b0;
      else        wrEn[t] <= strobes.wrStrobe[t];
    end
  end

  // R4: at most one write target per response
  a_r4_onehot_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrEn));

  // R5: every status write carries the fixed-one bit
  a_r5_fo_forced: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn[WT_STAT] |-> wrDataOut[FO_BIT]);

  // R6: redirect never coincides with a register write, always clears delay slot
  a_r6_redirect_excl: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (dsClear && wrEn == '0 && !rspErr));

  // R8: idle cycles are quiet
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> (wrEn == '0 && !redirect && !rspErr && rdData == '0));

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_access_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int IMPL_COUNT   = 'h800,
  parameter int SHADOW_BASE  = 'h400,
  parameter int SHADOW_DEPTH = 512,
  parameter int FO_BIT       = 15,
  parameter int IDX_W        = $clog2(SHADOW_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opValid,
  input  logic                opWrite,
  input  logic [ADDR_W-1:0]   opAddr,
  input  logic [DATA_W-1:0]   opData,
  input  logic                supMode,
  input  logic                userAccess,
  input  logic [DATA_W-1:0]   verVal,
  input  logic [DATA_W-1:0]   unitVal,
  input  logic [DATA_W-1:0]   cfgVal,
  input  logic [DATA_W-1:0]   statVal,
  input  logic [DATA_W-1:0]   prevPcVal,
  input  logic [DATA_W-1:0]   fpCtlVal,
  input  logic [DATA_W-1:0]   excPcVal,
  input  logic [DATA_W-1:0]   macLoVal,
  input  logic [DATA_W-1:0]   macHiVal,
  output logic [IDX_W-1:0]    shadowRdIdx,
  input  logic [DATA_W-1:0]   shadowRdData,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rdData,
  output logic [WT_COUNT-1:0] wrEn,
  output logic [DATA_W-1:0]   wrDataOut,
  output logic [IDX_W-1:0]    wrIdx,
  output logic                redirect,
  output logic [DATA_W-1:0]   redirectPc,
  output logic                dsClear
);

  ctlStrobes_t strobes;

  spr_access_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_COUNT(IMPL_COUNT),
    .SHADOW_BASE(SHADOW_BASE), .SHADOW_DEPTH(SHADOW_DEPTH)
  ) u_ctrl (
    .opValid(opValid), .opWrite(opWrite), .opAddr(opAddr), .opData(opData),
    .supMode(supMode), .userAccess(userAccess), .strobes(strobes)
  );

  spr_access_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHADOW_BASE(SHADOW_BASE),
    .IDX_W(IDX_W), .FO_BIT(FO_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .opAddr(opAddr), .opData(opData),
    .verVal(verVal), .unitVal(unitVal), .cfgVal(cfgVal), .statVal(statVal),
    .prevPcVal(prevPcVal), .fpCtlVal(fpCtlVal), .excPcVal(excPcVal),
    .macLoVal(macLoVal), .macHiVal(macHiVal),
    .shadowRdIdx(shadowRdIdx), .shadowRdData(shadowRdData),
    .rspValid(rspValid), .rspErr(rspErr), .rdData(rdData), .wrEn(wrEn),
    .wrDataOut(wrDataOut), .wrIdx(wrIdx), .redirect(redirect),
    .redirectPc(redirectPc), .dsClear(dsClear)
  );

  // R1: denied privilege always errors with no effect
  a_r1_priv_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !supMode && !userAccess) |=>
      (rspValid && rspErr && rdData == '0 && wrEn == '0 && !redirect));

  // R2: out-of-range addresses always error with no effect
  a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (32'(opAddr) >= 32'(IMPL_COUNT))) |=>
      (rspErr && rdData == '0 && wrEn == '0 && !redirect));

  // R7: zero write to the timer mode register is silent
  a_r7_timer_zero_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opWrite && (supMode || userAccess) &&
     32'(opAddr) == ADR_TMRMODE && opData == '0) |=>
      (rspValid && !rspErr && wrEn == '0 && !redirect));

endmodule

// File: tb/spr_access_unit_tb.sv
module spr_access_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OUT_W = 116;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0, opWrite = 1'b0;
  logic [11:0] opAddr = '0;
  logic [31:0] opData = '0;
  logic        supMode = 1'b0, userAccess = 1'b0;
  logic [8:0]  shadowRdIdx, wrIdx;
  logic [31:0] shadowRdData, rdData, wrDataOut, redirectPc;
  logic        rspValid, rspErr, redirect, dsClear;
  logic [6:0]  wrEn;

  localparam logic [31:0] V_VER = 32'h1100_0001, V_UNIT = 32'h2200_0002,
    V_CFG = 32'h3300_0003, V_STAT = 32'h4400_0004, V_PPC = 32'h5500_0005,
    V_FPC = 32'h6600_0006, V_EPC = 32'h7700_0007, V_MLO = 32'h8800_0008,
    V_MHI = 32'h9900_0009;

  assign shadowRdData = 32'hA5A5_0000 | 32'(shadowRdIdx);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_access_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opWrite(opWrite),
    .opAddr(opAddr), .opData(opData), .supMode(supMode), .userAccess(userAccess),
    .verVal(V_VER), .unitVal(V_UNIT), .cfgVal(V_CFG), .statVal(V_STAT),
    .prevPcVal(V_PPC), .fpCtlVal(V_FPC), .excPcVal(V_EPC),
    .macLoVal(V_MLO), .macHiVal(V_MHI),
    .shadowRdIdx(shadowRdIdx), .shadowRdData(shadowRdData),
    .rspValid(rspValid), .rspErr(rspErr), .rdData(rdData), .wrEn(wrEn),
    .wrDataOut(wrDataOut), .wrIdx(wrIdx), .redirect(redirect),
    .redirectPc(redirectPc), .dsClear(dsClear)
  );

  function automatic logic [OUT_W-1:0] pack(logic v, logic e, logic [31:0] rd,
      logic [6:0] we, logic [31:0] wd, logic [8:0] wi, logic rr,
      logic [31:0] rp, logic dc);
    return {v, e, rd, we, wd, wi, rr, rp, dc};
  endfunction

  task automatic compare(string tag, logic [OUT_W-1:0] exp);
    logic [OUT_W-1:0] act;
    act = pack(rspValid, rspErr, rdData, wrEn, wrDataOut, wrIdx, redirect,
               redirectPc, dsClear);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h wr=%0d sup=%0d usr=%0d act=%h exp=%h",
               tag, opAddr, opWrite, supMode, userAccess, act, exp);
    end
  endtask

  // Expected response computed from the requirements
  task automatic expect_of(input logic w, input int a, input logic [31:0] d,
      input logic s, input logic u, output string tag,
      output logic [OUT_W-1:0] exp);
    logic e = 0; logic [31:0] rd = 0; logic [6:0] we = 0; logic [31:0] wd = 0;
    logic [8:0] wi = 0; logic rr = 0; logic [31:0] rp = 0;
    bit win;
    win = (a >= 'h400) && (a < 'h600);
    if (!(s || u)) begin tag = "R1"; e = 1; end
    else if (a >= 'h800) begin tag = "R2"; e = 1; end
    else if (!w) begin
      tag = win ? "R10" : "R3";
      if (win) rd = 32'hA5A5_0000 | 32'(a - 'h400);
      else case (a)
        'h000: rd = V_VER;  'h001: rd = V_UNIT; 'h002: rd = V_CFG;
        'h011: rd = V_STAT; 'h012: rd = V_PPC;  'h014: rd = V_FPC;
        'h020: rd = V_EPC;  'h280: rd = V_MLO;  'h281: rd = V_MHI;
        default: e = 1;
      endcase
    end else begin
      tag = "R4";
      if (win) begin tag = "R10"; we = 7'h40; wd = d; wi = 9'(a - 'h400); end
      else case (a)
        'h014: begin we = 7'h01; wd = d; end
        'h020: begin we = 7'h02; wd = d; end
        'h040: begin we = 7'h04; wd = d; end
        'h280: begin we = 7'h08; wd = d; end
        'h281: begin we = 7'h10; wd = d; end
        'h011: begin tag = "R5"; we = 7'h20; wd = d | 32'h0000_8000; end
        'h010: begin tag = "R6"; rr = 1; rp = d; end
        'h600: begin tag = "R7"; e = (d != 0); end
        default: e = 1;
      endcase
    end
    exp = pack(1'b1, e, rd, we, wd, wi, rr, rp, rr);
  endtask

  task automatic do_op(input logic w, input int a, input logic [31:0] d,
                       input logic s, input logic u);
    string tag; logic [OUT_W-1:0] exp;
    @(negedge clk);
    opValid = 1; opWrite = w; opAddr = 12'(a); opData = d;
    supMode = s; userAccess = u;
    expect_of(w, a, d, s, u, tag, exp);
    @(negedge clk);
    opValid = 0;
    compare({tag, " (R8 latency)"}, exp);
  endtask

  task automatic sweep(input logic s, input logic u);
    for (int a = 0; a < 4096; a++) begin
      do_op(1'b0, a, 32'h0, s, u);
      do_op(1'b1, a, {12'(a), 20'h01234}, s, u);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: outputs held at zero in reset even with a request present
    opValid = 1; opWrite = 1; opAddr = 12'h010; opData = 32'hDEAD_BEEF; supMode = 1;
    repeat (3) @(negedge clk);
    compare("R9 reset", '0);
    opValid = 0;
    rst_n = 1;
    @(negedge clk);
    compare("R9 after reset idle", '0);

    sweep(1'b1, 1'b0);   // supervisor
    sweep(1'b0, 1'b1);   // user access bit only
    sweep(1'b0, 1'b0);   // R1: no privilege

    // R5: status write with FO already set
    do_op(1'b1, 'h011, 32'hFFFF_FFFF, 1'b1, 1'b1);
    do_op(1'b1, 'h011, 32'h0000_0000, 1'b1, 1'b0);
    // R6: redirect targets
    do_op(1'b1, 'h010, 32'h8000_0100, 1'b1, 1'b0);
    do_op(1'b1, 'h010, 32'h0000_0000, 1'b0, 1'b1);
    // R7: zero and nonzero timer-mode writes
    do_op(1'b1, 'h600, 32'h0, 1'b1, 1'b0);
    do_op(1'b1, 'h600, 32'h0000_0001, 1'b1, 1'b0);
    do_op(1'b1, 'h600, 32'h0, 1'b0, 1'b0);
    // R10: window edges
    do_op(1'b1, 'h5FF, 32'h1357_9BDF, 1'b1, 1'b0);
    do_op(1'b0, 'h3FF, 32'h0, 1'b1, 1'b0);
    // R8: idle cycle after a response is all zero
    @(negedge clk);
    compare("R8 idle", '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule